// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This engine moves a block of bytes between a local sector buffer and system memory by following a table of region descriptors held in memory. A start pulse provides the table base address, the number of bytes to move and the direction. The walker fetches one descriptor at a time and splits each region into bursts. It hands every burst to a memory port as a request that carries the memory address, the byte length and the offset into the local buffer. The data beats of a burst travel between the memory system and the buffer outside this block. The walker only waits for the completion pulse of each burst.

A descriptor is 8 bytes long and made of two little-endian 32-bit words. The first word is the region address. The second word is a size/flag word. The walk ends in one of two ways. Completion means the requested byte count has been fully moved. Exhaustion means the table ran out first, either because a region flagged as last was used up or because one 4 KiB page of descriptors was read without such a flag. An abort input stops the walk at once.

Top module: `sgDmaWalker`

## Requirements
- R1: A descriptor fetch is a single request with `memReqDesc`=1, `memReqBytes`=8 and `memReqAddr` equal to the descriptor pointer. It is followed by two `memRdValid` beats: the first carries the region address and the second carries the size/flag word.
- R2: The region byte count is size-word bits [15:0] with bit 0 forced to zero. Bits [30:16] are ignored.
- R3: A decoded region byte count of zero stands for a 65536-byte region.
- R4: Bit 31 of the size word marks the last descriptor. If that region is used up while buffer bytes remain, `doneShort` pulses for one cycle and no further descriptor is fetched.
- R5: The descriptor pointer starts at `tableBase` and advances by 8 after each fetch, so successive fetches read base, base+8, base+16 and so on.
- R6: When a new descriptor is needed and the pointer is 4096 or more bytes past `tableBase`, the walk ends with `doneShort` even though no last flag was seen.
- R7: Each data burst moves the smallest of three values: the buffer bytes left, the region bytes left, and 64 (16 beats of 32 bits). After the burst, the region address and the buffer offset advance by that amount. Buffer offsets start at 0.
- R8: `doneOk` pulses for one cycle once the buffer count reaches zero. When the final burst empties the buffer and a last-flagged region in the same step, the outcome is `doneOk`, not `doneShort`. The two pulses never coincide.
- R9: While `memReqValid` is high and `memReqReady` is low, the request stays valid and its address and length stay constant.
- R10: An `abortReq` pulse makes `busy` and `memReqValid` low from the next cycle. No burst or completion follows it. The next start begins with a fresh descriptor fetch at the new base.
- R11: A start with a byte count of zero gives `doneOk` without any memory request.
- R12: `memReqWrite` equals the direction bit latched at start for data bursts, and is 0 for descriptor fetches.
- R13: After reset, `busy`, `memReqValid`, `doneOk` and `doneShort` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, taken only while idle |
| abortReq | input | 1 | Abort pulse, returns to idle |
| dirToMem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| tableBase | input | 32 | Byte address of the descriptor table |
| xferBytes | input | 17 | Number of buffer bytes to move |
| memReqReady | input | 1 | Memory accepts the request |
| memRdValid | input | 1 | Descriptor word beat valid |
| memRdData | input | 32 | Descriptor word beat |
| memDone | input | 1 | Data burst finished |
| busy | output | 1 | Walk in progress |
| doneOk | output | 1 | One-cycle pulse: buffer fully moved |
| doneShort | output | 1 | One-cycle pulse: table exhausted first |
| memReqValid | output | 1 | Request valid |
| memReqDesc | output | 1 | Request is a descriptor fetch |
| memReqWrite | output | 1 | Data burst writes memory |
| memReqAddr | output | 32 | Request byte address |
| memReqBytes | output | 7 | Request byte length |
| memReqBufOfs | output | 17 | Local buffer offset of a data burst |

## Verification
Two end conditions can fall in the same step: draining the local buffer and using up a last-flagged region. The bench provokes this with a single 64-byte last region and a 64-byte transfer, so the final burst ends both together. It judges the outcome by requiring a `doneOk` pulse with no `doneShort` and exactly one burst. A second pair, abort and an in-flight burst completion, is provoked by aborting while bursts stream. That case is judged by the absence of any later burst or end pulse and by a clean restart from a new table base.

// File: rtl/sgDmaPkg.sv
package sgDmaPkg;
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 8;
  localparam int REGION_W   = 17;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DREQ, ST_DW0, ST_DW1, ST_XREQ, ST_XWAIT
  } walkState_e;

  typedef struct packed {
    logic loadStart;
    logic clearRegion;
    logic advPtr;
    logic takeAddr;
    logic takeSize;
    logic takeChunk;
  } pathCmd_t;
endpackage

// File: rtl/sgDmaPath.sv
module sgDmaPath
  import sgDmaPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BUF_W       = 17,
  parameter int BURST_BYTES = 64,
  parameter int PAGE_BYTES  = 4096,
  parameter int CHUNK_W     = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathCmd_t           cmd,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [BUF_W-1:0]   xferBytes,
  input  logic               dirToMem,
  input  logic [WORD_W-1:0]  rdWord,
  output logic [ADDR_W-1:0]  descPtr,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [BUF_W-1:0]   bufOfs,
  output logic [CHUNK_W-1:0] chunkBytes,
  output logic               dirQ,
  output logic               bufEmpty,
  output logic               regEmpty,
  output logic               tableEnd
);
  logic [ADDR_W-1:0]   baseQ, ptrQ, regAddrQ;
  logic [REGION_W-1:0] regLeftQ;
  logic [BUF_W-1:0]    bufLeftQ, bufOfsQ;
  logic                lastQ;
  logic [31:0]         bufL32, regL32, minBR, chunk32;
  logic [REGION_W-1:0] decLen;

  always_comb begin
    bufL32  = 32'(bufLeftQ);
    regL32  = 32'(regLeftQ);
    minBR   = (bufL32 < regL32) ? bufL32 : regL32;
    chunk32 = (minBR < 32'(BURST_BYTES)) ? minBR : 32'(BURST_BYTES);
    decLen  = (rdWord[15:1] == '0) ? REGION_W'(65536)
                                   : {1'b0, rdWord[15:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; ptrQ <= '0; regAddrQ <= '0; regLeftQ <= '0;
      bufLeftQ <= '0; bufOfsQ <= '0; lastQ <= 1'b0; dirQ <= 1'b0;
    end else if (cmd.clearRegion) begin
      regLeftQ <= '0;
      lastQ    <= 1'b0;
    end else begin
      if (cmd.loadStart) begin
        baseQ    <= tableBase;
        ptrQ     <= tableBase;
        bufLeftQ <= xferBytes;
        bufOfsQ  <= '0;
        regLeftQ <= '0;
        lastQ    <= 1'b0;
        dirQ     <= dirToMem;
      end
      if (cmd.advPtr)   ptrQ <= ptrQ + ADDR_W'(DESC_BYTES);
      if (cmd.takeAddr) regAddrQ <= ADDR_W'(rdWord);
      if (cmd.takeSize) begin
        regLeftQ <= decLen;
        lastQ    <= rdWord[31];
      end
      if (cmd.takeChunk) begin
        regAddrQ <= regAddrQ + ADDR_W'(chunkBytes);
        regLeftQ <= regLeftQ - REGION_W'(chunkBytes);
        bufLeftQ <= bufLeftQ - BUF_W'(chunkBytes);
        bufOfsQ  <= bufOfsQ + BUF_W'(chunkBytes);
      end
    end
  end

  assign chunkBytes = chunk32[CHUNK_W-1:0];
  assign descPtr    = ptrQ;
  assign regAddr    = regAddrQ;
  assign bufOfs     = bufOfsQ;
  assign bufEmpty   = (bufLeftQ == '0);
  assign regEmpty   = (regLeftQ == '0);
  assign tableEnd   = lastQ || ((ptrQ - baseQ) >= ADDR_W'(PAGE_BYTES));

  // R7: a burst never exceeds what is left in the region or the buffer
  assert_chunk_fits_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.takeChunk |-> (chunkBytes != '0) && (REGION_W'(chunkBytes) <= regLeftQ)
                      && (BUF_W'(chunkBytes) <= bufLeftQ));
endmodule

// File: rtl/sgDmaCtrl.sv
module sgDmaCtrl
  import sgDmaPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     abortReq,
  input  logic     memReqReady,
  input  logic     memRdValid,
  input  logic     memDone,
  input  logic     bufEmpty,
  input  logic     regEmpty,
  input  logic     tableEnd,
  output pathCmd_t cmd,
  output logic     memReqValid,
  output logic     memReqDesc,
  output logic     busy,
  output logic     doneOk,
  output logic     doneShort
);
  walkState_e stateQ, stateD;

  always_comb begin
    cmd             = '0;
    cmd.loadStart   = (stateQ == ST_IDLE) && startReq && !abortReq;
    cmd.clearRegion = abortReq;
    cmd.advPtr      = (stateQ == ST_DREQ) && memReqReady && !abortReq;
    cmd.takeAddr    = (stateQ == ST_DW0) && memRdValid && !abortReq;
    cmd.takeSize    = (stateQ == ST_DW1) && memRdValid && !abortReq;
    cmd.takeChunk   = (stateQ == ST_XREQ) && memReqReady && !abortReq;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (cmd.loadStart) stateD = ST_CHECK;
      ST_CHECK: begin
        if (bufEmpty)      stateD = ST_IDLE;
        else if (regEmpty) stateD = tableEnd ? ST_IDLE : ST_DREQ;
        else               stateD = ST_XREQ;
      end
      ST_DREQ:  if (memReqReady) stateD = ST_DW0;
      ST_DW0:   if (memRdValid)  stateD = ST_DW1;
      ST_DW1:   if (memRdValid)  stateD = ST_CHECK;
      ST_XREQ:  if (memReqReady) stateD = ST_XWAIT;
      ST_XWAIT: if (memDone)     stateD = ST_CHECK;
      default:  stateD = ST_IDLE;
    endcase
    if (abortReq) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReqValid = ((stateQ == ST_DREQ) || (stateQ == ST_XREQ)) && !abortReq;
  assign memReqDesc  = (stateQ == ST_DREQ);
  assign busy        = (stateQ != ST_IDLE);
  assign doneOk      = (stateQ == ST_CHECK) && bufEmpty && !abortReq;
  assign doneShort   = (stateQ == ST_CHECK) && !bufEmpty && regEmpty && tableEnd
                       && !abortReq;

  // R8: the two end pulses are exclusive
  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneShort));
  // R9: a stalled request stays up unless aborted
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid || abortReq));
  // R10: abort leaves the walker idle on the next cycle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !busy);
  // R8: an end pulse is followed by idle
  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneOk || doneShort) |=> !busy);
endmodule

// File: rtl/sgDmaWalker.sv
module sgDmaWalker
  import sgDmaPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BUF_W       = 17,
  parameter int BURST_BEATS = 16,
  parameter int PAGE_BYTES  = 4096,
  localparam int BURST_BYTES = BURST_BEATS * (WORD_W / 8),
  localparam int CHUNK_W     = $clog2(BURST_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               abortReq,
  input  logic               dirToMem,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [BUF_W-1:0]   xferBytes,
  input  logic               memReqReady,
  input  logic               memRdValid,
  input  logic [WORD_W-1:0]  memRdData,
  input  logic               memDone,
  output logic               busy,
  output logic               doneOk,
  output logic               doneShort,
  output logic               memReqValid,
  output logic               memReqDesc,
  output logic               memReqWrite,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [CHUNK_W-1:0] memReqBytes,
  output logic [BUF_W-1:0]   memReqBufOfs
);
  pathCmd_t           cmd;
  logic [ADDR_W-1:0]  descPtr, regAddr;
  logic [CHUNK_W-1:0] chunkBytes;
  logic               dirQ, bufEmpty, regEmpty, tableEnd;

  sgDmaCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .memReqReady(memReqReady), .memRdValid(memRdValid), .memDone(memDone),
    .bufEmpty(bufEmpty), .regEmpty(regEmpty), .tableEnd(tableEnd),
    .cmd(cmd), .memReqValid(memReqValid), .memReqDesc(memReqDesc),
    .busy(busy), .doneOk(doneOk), .doneShort(doneShort)
  );

  sgDmaPath #(
    .ADDR_W(ADDR_W), .BUF_W(BUF_W), .BURST_BYTES(BURST_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .CHUNK_W(CHUNK_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tableBase(tableBase),
    .xferBytes(xferBytes), .dirToMem(dirToMem), .rdWord(memRdData),
    .descPtr(descPtr), .regAddr(regAddr), .bufOfs(memReqBufOfs),
    .chunkBytes(chunkBytes), .dirQ(dirQ), .bufEmpty(bufEmpty),
    .regEmpty(regEmpty), .tableEnd(tableEnd)
  );

  assign memReqAddr  = memReqDesc ? descPtr : regAddr;
  assign memReqBytes = memReqDesc ? CHUNK_W'(DESC_BYTES) : chunkBytes;
  assign memReqWrite = !memReqDesc && dirQ;

  // R9: request fields are frozen while stalled
  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !abortReq) |=>
      (abortReq || ($stable(memReqAddr) && $stable(memReqBytes))));
  // R1: descriptor fetches are always 8 bytes
  assert_desc_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqDesc) |-> (memReqBytes == CHUNK_W'(DESC_BYTES)));
  // R7: data bursts are never empty nor longer than one burst
  assert_burst_max_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqDesc) |->
      ((memReqBytes != '0) && (memReqBytes <= CHUNK_W'(BURST_BYTES))));
  // R12: descriptor fetches are reads
  assert_desc_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqDesc |-> !memReqWrite);
endmodule

// File: tb/sgDmaWalker_tb.sv
module sgDmaWalker_tb_top;
  localparam int LOGMAX = 1200;
  localparam int NDESC  = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, abortReq = 1'b0, dirToMem = 1'b0;
  logic [31:0] tableBase = '0;
  logic [16:0] xferBytes = '0;
  logic        memReqReady, memRdValid, memDone;
  logic [31:0] memRdData;
  logic        busy, doneOk, doneShort, memReqValid, memReqDesc, memReqWrite;
  logic [31:0] memReqAddr;
  logic [6:0]  memReqBytes;
  logic [16:0] memReqBufOfs;

  sgDmaWalker dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .dirToMem(dirToMem), .tableBase(tableBase), .xferBytes(xferBytes),
    .memReqReady(memReqReady), .memRdValid(memRdValid), .memRdData(memRdData),
    .memDone(memDone), .busy(busy), .doneOk(doneOk), .doneShort(doneShort),
    .memReqValid(memReqValid), .memReqDesc(memReqDesc), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqBytes(memReqBytes), .memReqBufOfs(memReqBufOfs)
  );

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  int cyc = 0;

  // descriptor table and memory responder
  logic [31:0] dAddr [NDESC];
  logic [31:0] dSize [NDESC];
  logic [31:0] tbBase = '0;
  logic        stallMode = 1'b0, clearReq = 1'b0;
  int          rdPhase = 0, rdIdx = 0;
  int          logN = 0, descSeen = 0, descAddrErr = 0;
  logic [31:0] logAddr [LOGMAX];
  int          logBytes [LOGMAX];
  int          logOfs [LOGMAX];
  logic        logWr [LOGMAX];
  logic        doneQ = 1'b0;

  assign memReqReady = stallMode ? (cyc % 3 == 0) : 1'b1;
  assign memRdValid  = (rdPhase != 0);
  assign memRdData   = (rdPhase == 1) ? dAddr[rdIdx] : dSize[rdIdx];
  assign memDone     = doneQ;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    doneQ <= 1'b0;
    if (rdPhase == 1) rdPhase <= 2;
    else if (rdPhase == 2) rdPhase <= 0;
    if (clearReq) begin
      logN <= 0; descSeen <= 0; descAddrErr <= 0;
    end else if (memReqValid && memReqReady) begin
      if (memReqDesc) begin
        if (memReqAddr != tbBase + 32'(descSeen * 8)) descAddrErr <= descAddrErr + 1;
        rdIdx    <= int'((memReqAddr - tbBase) >> 3) % NDESC;
        rdPhase  <= 1;
        descSeen <= descSeen + 1;
      end else begin
        if (logN < LOGMAX) begin
          logAddr[logN]  <= memReqAddr;
          logBytes[logN] <= int'(memReqBytes);
          logOfs[logN]   <= int'(memReqBufOfs);
          logWr[logN]    <= memReqWrite;
        end
        logN  <= logN + 1;
        doneQ <= 1'b1;
      end
    end
  end

  // monitor sampled after the edge has settled
  int okCnt = 0, shortCnt = 0, holdErr = 0;
  logic prevStall = 1'b0;
  logic [31:0] prevAddr = '0;
  logic [6:0]  prevBytes = '0;
  always @(posedge clk) begin
    #2;
    if (doneOk) okCnt++;
    if (doneShort) shortCnt++;
    if (prevStall && (!memReqValid || memReqAddr != prevAddr || memReqBytes != prevBytes))
      holdErr++;
    prevStall = memReqValid && !memReqReady && !abortReq;
    prevAddr  = memReqAddr;
    prevBytes = memReqBytes;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // independent reference of the walk
  logic [31:0] expAddr [LOGMAX];
  int expBytes [LOGMAX];
  int expOfs [LOGMAX];
  int expN, expFetch;
  bit expShort;

  task automatic buildExpected(input int total);
    int bufLeft = total, ptrOff = 0, regLeft = 0, ofs = 0, ch;
    logic [31:0] regA = '0;
    bit last = 0;
    expN = 0; expFetch = 0; expShort = 0;
    forever begin
      if (bufLeft == 0) break;
      if (regLeft == 0) begin
        if (last || ptrOff >= 4096) begin expShort = 1; break; end
        regA    = dAddr[ptrOff / 8];
        regLeft = int'(dSize[ptrOff / 8] & 32'h0000_fffe);
        if (regLeft == 0) regLeft = 65536;
        last    = dSize[ptrOff / 8][31];
        ptrOff += 8;
        expFetch++;
      end
      ch = (bufLeft < regLeft) ? bufLeft : regLeft;
      if (ch > 64) ch = 64;
      if (expN < LOGMAX) begin
        expAddr[expN] = regA; expBytes[expN] = ch; expOfs[expN] = ofs;
      end
      expN++;
      regA += 32'(ch); regLeft -= ch; bufLeft -= ch; ofs += ch;
    end
  endtask

  task automatic clearTable(input logic [31:0] sz);
    for (int i = 0; i < NDESC; i++) begin
      dAddr[i] = 32'h5000_0000 + 32'(i * 256);
      dSize[i] = sz;
    end
  endtask

  task automatic clearLogs();
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
  endtask

  task automatic runWalk(input string tag, input int total, input bit dir,
                         input logic [31:0] base, input bit stall);
    int ok0, sh0, bad = 0, waitCnt = 0;
    buildExpected(total);
    tbBase = base;
    clearLogs();
    stallMode = stall;
    ok0 = okCnt; sh0 = shortCnt; holdErr = 0;
    @(negedge clk);
    tableBase = base; dirToMem = dir; xferBytes = 17'(total); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    while (okCnt == ok0 && shortCnt == sh0 && waitCnt < 120000) begin
      @(negedge clk); waitCnt++;
    end
    repeat (3) @(negedge clk);
    stallMode = 1'b0;
    check(okCnt - ok0 == (expShort ? 0 : 1), tag, "doneOk pulses", okCnt - ok0, expShort ? 0 : 1);
    check(shortCnt - sh0 == (expShort ? 1 : 0), tag, "doneShort pulses", shortCnt - sh0, expShort ? 1 : 0);
    check(logN == expN, tag, "burst count", logN, expN);
    check(descSeen == expFetch, tag, "descriptor fetches", descSeen, expFetch);
    check(descAddrErr == 0, tag, "descriptor pointer steps", descAddrErr, 0);
    for (int i = 0; i < expN && i < LOGMAX && i < logN; i++) begin
      if (logAddr[i] != expAddr[i] || logBytes[i] != expBytes[i] ||
          logOfs[i] != expOfs[i] || logWr[i] != dir) begin
        if (bad == 0)
          $display("burst %0d: addr %h/%h bytes %0d/%0d ofs %0d/%0d wr %0d/%0d", i,
                   logAddr[i], expAddr[i], logBytes[i], expBytes[i],
                   logOfs[i], expOfs[i], logWr[i], dir);
        bad++;
      end
    end
    check(bad == 0, tag, "burst contents", bad, 0);
    if (stall) check(holdErr == 0, tag, "stalled request held", holdErr, 0);
  endtask

  task automatic testReset();
    check(!busy && !memReqValid && !doneOk && !doneShort, "R13", "reset outputs",
          {busy, memReqValid, doneOk, doneShort}, 0);
  endtask

  task automatic setTwoRegions();
    clearTable(32'h0);
    dAddr[0] = 32'h8000_0003; dSize[0] = 32'h0000_0064;
    dAddr[1] = 32'h9000_0000; dSize[1] = 32'h8000_00c8;
  endtask

  task automatic testReadWalk();   // R1 R5 R7
    setTwoRegions();
    runWalk("R1_R5_R7", 300, 1'b0, 32'h2000_0100, 1'b0);
  endtask

  task automatic testWriteWalk();  // R12
    setTwoRegions();
    runWalk("R12", 150, 1'b1, 32'h2000_0200, 1'b0);
  endtask

  task automatic testOddSize();    // R2 R4
    clearTable(32'h0);
    dAddr[0] = 32'h8100_0000; dSize[0] = 32'h0000_0065;
    dAddr[1] = 32'h8200_0010; dSize[1] = 32'h8000_0011;
    runWalk("R2_R4", 200, 1'b0, 32'h2100_0000, 1'b0);
  endtask

  task automatic testZeroCount();  // R3 R2
    clearTable(32'h0);
    dAddr[0] = 32'h8300_0000; dSize[0] = 32'h8abc_0000;
    runWalk("R3", 65540, 1'b1, 32'h2200_0000, 1'b0);
  endtask

  task automatic testSameStep();   // R8
    clearTable(32'h0);
    dAddr[0] = 32'h8400_0000; dSize[0] = 32'h8000_0040;
    runWalk("R8", 64, 1'b0, 32'h2300_0000, 1'b0);
  endtask

  task automatic testPageLimit();  // R6
    clearTable(32'h0000_0002);
    runWalk("R6", 2000, 1'b0, 32'h3000_0f00, 1'b0);
  endtask

  task automatic testZeroBytes();  // R11
    setTwoRegions();
    runWalk("R11", 0, 1'b0, 32'h2400_0000, 1'b0);
  endtask

  task automatic testStall();      // R9
    setTwoRegions();
    runWalk("R9", 300, 1'b1, 32'h2500_0000, 1'b1);
  endtask

  task automatic testAbort();      // R10
    int snapN, ok0, sh0, waitCnt = 0;
    clearTable(32'h0);
    dAddr[0] = 32'h8600_0000; dSize[0] = 32'h8000_0000;
    tbBase = 32'h2600_0000;
    clearLogs();
    @(negedge clk);
    tableBase = tbBase; dirToMem = 1'b0; xferBytes = 17'd4000; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    while (logN < 3 && waitCnt < 1000) begin @(negedge clk); waitCnt++; end
    ok0 = okCnt; sh0 = shortCnt;
    abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    check(!busy && !memReqValid, "R10", "idle after abort", {busy, memReqValid}, 0);
    snapN = logN;
    repeat (20) @(negedge clk);
    check(logN == snapN, "R10", "no burst after abort", logN, snapN);
    check(okCnt == ok0 && shortCnt == sh0, "R10", "no end pulse after abort",
          okCnt + shortCnt, ok0 + sh0);
    clearTable(32'h0);
    dAddr[0] = 32'h8700_0000; dSize[0] = 32'h8000_0040;
    runWalk("R10", 64, 1'b0, 32'h2700_0000, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < LOGMAX; i++) begin
      logAddr[i] = '0; logBytes[i] = 0; logOfs[i] = 0; logWr[i] = 1'b0;
    end
    clearTable(32'h0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadWalk();
    testWriteWalk();
    testOddSize();
    testZeroCount();
    testSameStep();
    testPageLimit();
    testZeroBytes();
    testStall();
    testAbort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule